// File: doc/BRIEF.md
# Transmit FIFO Watermark Request and Control-Data Status

This block holds a transmit FIFO whose free space is compared with a watermark that software selects. When free space is above that watermark, the block raises a transfer-request flag. A DMA controller can service the flag through a request/acknowledge pair, or a CPU can service it through an interrupt. Each DMA acknowledge writes one word into the FIFO. The request then drops for exactly one cycle and comes back on its own if the free-space condition still holds. The serial side drains the FIFO through a valid/ready stream.

Beside the FIFO sits a control-data holding register. The serial side loads it with a strobe, and a ready flag marks it as holding valid data. A CPU read of the register returns its value and clears the flag. The register port also gives access to the status flags, a control register (enables and watermark select) and an interrupt-enable register. The interrupt output is the OR of every asserted flag whose enable bit is set.

Back-pressure on the drain stream follows these rules. A word leaves the FIFO only in a cycle where `txo_valid` and `txo_ready` are both high. While `txo_valid` is high, `txo_data` holds the oldest word. The block raises `txo_valid` only while the FIFO holds data and transmit is enabled. The control-data strobe and the DMA acknowledge are always accepted, and neither can be stalled.

Top module: `txwm_ctrl`

Register map (`cpu_addr`):
- 0: transmit data, write only. A write pushes one word.
- 1: status. Bit 0 is control-ready, bit 1 is reserved and reads 0, bit 2 is transmit request, and bit 3 is sticky overflow, cleared by writing 1.
- 2: control. Bit 0 is transmit enable, bit 1 is receive enable, bit 2 is DMA-mode enable, and bits 5:4 are the watermark select.
- 3: interrupt enable. It uses the same bit positions as status, and bit 1 always reads 0.
- 4: control data, read only. A read with `cpu_rd` clears control-ready.

## Requirements
- R1: While transmit enable (control bit 0) is 1, status bit 2 is 1 exactly when the FIFO free space (DEPTH minus occupancy) is greater than the threshold chosen by control bits 5:4. The thresholds are: 0 selects 1 word, 1 selects DEPTH/4, 2 selects DEPTH/2, and 3 selects 3*DEPTH/4. The flag follows occupancy with no clear from software.
- R2: While transmit enable is 0, status bit 2 reads 0 and `dma_req` is 0.
- R3: A cycle with `dma_ack` high pushes `dma_wdata`. In the following cycle the request flag and `dma_req` are 0, and in the cycle after that they show the free-space condition again. `dma_req` equals status bit 2 while DMA-mode enable (control bit 2) is 1, and is 0 otherwise.
- R4: A CPU write to address 0 pushes `cpu_wdata` into the FIFO. The write is dropped, and status bit 3 is set, when the FIFO is full or when `dma_ack` is high in the same cycle. Writing 1 to status bit 3 clears it.
- R5: `txo_valid` is 1 only while the FIFO holds data and transmit is enabled. A word leaves only when `txo_valid` and `txo_ready` are both 1. Words leave in the order they were pushed.
- R6: A `ctl_load` strobe while receive enable (control bit 1) is 1 stores `ctl_data` and sets status bit 0. A strobe that arrives while the flag is already set overwrites the stored value with the newest one, and the flag stays 1.
- R7: A read of address 4 returns the stored control data and clears status bit 0. Status bit 0 reads 0 while receive enable is 0. A strobe while receive enable is 0 is ignored.
- R8: Status bit 1 and interrupt-enable bit 1 always read 0.
- R9: `irq` is 1 exactly when some status bit among 0, 2 and 3 is 1 and the interrupt-enable bit at the same position is 1.
- R10: After reset, the FIFO is empty and every register and flag is 0, so `irq`, `dma_req` and `txo_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (side effects) |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data (combinational) |
| dma_req | output | 1 | Transfer request to DMA controller |
| dma_ack | input | 1 | DMA write of one FIFO word |
| dma_wdata | input | DATA_W | DMA write data |
| txo_valid | output | 1 | Drain stream valid |
| txo_ready | input | 1 | Drain stream ready |
| txo_data | output | DATA_W | Drain stream data |
| ctl_load | input | 1 | Control-data load strobe |
| ctl_data | input | DATA_W | Control data to store |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=8 and DATA_W=16. At that depth the four thresholds are 1, 2, 4 and 6 words, so a sweep can visit every occupancy from empty to full under every watermark select. At each step the expected request flag is computed from DEPTH minus the fill level. The small depth also keeps full-FIFO overflow, the one-cycle DMA gap and in-order draining of each full load within a few hundred cycles.

// File: rtl/txwm_pkg.sv
package txwm_pkg;
  localparam logic [2:0] ADDR_TXDATA = 3'd0;
  localparam logic [2:0] ADDR_STATUS = 3'd1;
  localparam logic [2:0] ADDR_CTRL   = 3'd2;
  localparam logic [2:0] ADDR_IRQEN  = 3'd3;
  localparam logic [2:0] ADDR_CTLDAT = 3'd4;

  localparam int BIT_CTLRDY = 0;
  localparam int BIT_TXREQ  = 2;
  localparam int BIT_OVF    = 3;

  typedef enum logic [1:0] {
    WM_ONE     = 2'd0,
    WM_QUARTER = 2'd1,
    WM_HALF    = 2'd2,
    WM_3QUART  = 2'd3
  } wm_sel_e;
endpackage

// File: rtl/txwm_fifo.sv
module txwm_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full     = (count == DEPTH_C);
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
  assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/txwm_req_gen.sv
module txwm_req_gen #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          dma_en,
  input  logic [1:0]    wm_sel,
  input  logic [CW-1:0] free,
  input  logic          dma_ack,
  output logic          tx_req,
  output logic          dma_req
);
  import txwm_pkg::*;

  logic [CW-1:0] thr;
  logic          ack_gap_q;

  always_comb begin
    case (wm_sel_e'(wm_sel))
      WM_ONE:     thr = CW'(1);
      WM_QUARTER: thr = CW'(DEPTH / 4);
      WM_HALF:    thr = CW'(DEPTH / 2);
      default:    thr = CW'((3 * DEPTH) / 4);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_gap_q <= 1'b0;
    else        ack_gap_q <= dma_ack;
  end

  assign tx_req  = tx_en && (free > thr) && !ack_gap_q;
  assign dma_req = tx_req && dma_en;

  assert_ack_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_req);
  assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !dma_req);
  assert_req_space_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (free != '0));
endmodule

// File: rtl/txwm_ctl_hold.sv
module txwm_ctl_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] held,
  output logic              rdy
);
  logic rdy_q;
  logic take;

  assign take = load && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (take) held <= load_data;
      if (take)        rdy_q <= 1'b1;
      else if (rd_clr) rdy_q <= 1'b0;
    end
  end

  assign rdy = rdy_q && rx_en;

  assert_load_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rdy_q);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !take) |=> !rdy_q);
  assert_ignore_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en) |=> $stable(held));
endmodule

// File: rtl/txwm_ctrl.sv
module txwm_ctrl #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [2:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              txo_valid,
  input  logic              txo_ready,
  output logic [DATA_W-1:0] txo_data,
  input  logic              ctl_load,
  input  logic [DATA_W-1:0] ctl_data,
  output logic              irq
);
  import txwm_pkg::*;

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic              tx_en_q, rx_en_q, dma_en_q;
  logic [1:0]        wm_q;
  logic [3:0]        ie_q;
  logic              ovf_q;
  logic              cpu_push, drop, push, pop, full, empty;
  logic [DATA_W-1:0] push_data, held;
  logic [CW-1:0]     count, free;
  logic              tx_req, ctl_rdy, ovf_clr;
  logic [3:0]        status;

  assign cpu_push  = cpu_wr && (cpu_addr == ADDR_TXDATA);
  assign push      = dma_ack || cpu_push;
  assign push_data = dma_ack ? dma_wdata : cpu_wdata;
  assign drop      = (cpu_push && (dma_ack || full)) || (dma_ack && full);
  assign pop       = txo_valid && txo_ready;
  assign txo_valid = !empty && tx_en_q;
  assign free      = DEPTH_C - count;
  assign ovf_clr   = cpu_wr && (cpu_addr == ADDR_STATUS) && cpu_wdata[BIT_OVF];

  txwm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(txo_data), .count(count), .full(full), .empty(empty)
  );

  txwm_req_gen #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en_q), .dma_en(dma_en_q),
    .wm_sel(wm_q), .free(free), .dma_ack(dma_ack),
    .tx_req(tx_req), .dma_req(dma_req)
  );

  txwm_ctl_hold #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en_q), .load(ctl_load),
    .load_data(ctl_data), .rd_clr(cpu_rd && (cpu_addr == ADDR_CTLDAT)),
    .held(held), .rdy(ctl_rdy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      dma_en_q <= 1'b0;
      wm_q     <= 2'd0;
      ie_q     <= 4'd0;
      ovf_q    <= 1'b0;
    end else begin
      if (cpu_wr && (cpu_addr == ADDR_CTRL)) begin
        tx_en_q  <= cpu_wdata[0];
        rx_en_q  <= cpu_wdata[1];
        dma_en_q <= cpu_wdata[2];
        wm_q     <= cpu_wdata[5:4];
      end
      if (cpu_wr && (cpu_addr == ADDR_IRQEN))
        ie_q <= {cpu_wdata[3:2], 1'b0, cpu_wdata[0]};
      if (drop)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign status = {ovf_q, tx_req, 1'b0, ctl_rdy};
  assign irq    = |(status & ie_q);

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      ADDR_STATUS: cpu_rdata[3:0] = status;
      ADDR_CTRL:   cpu_rdata[5:0] = {wm_q, 1'b0, dma_en_q, rx_en_q, tx_en_q};
      ADDR_IRQEN:  cpu_rdata[3:0] = ie_q;
      ADDR_CTLDAT: cpu_rdata      = held;
      default:     cpu_rdata      = '0;
    endcase
  end

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q != 4'd0));
  assert_txo_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txo_valid |-> tx_en_q);
endmodule

// File: tb/test_txwm_ctrl.sv
module test_txwm_ctrl;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cpu_wr = 0, cpu_rd = 0, dma_ack = 0, txo_ready = 0, ctl_load = 0;
  logic [2:0]    cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, dma_wdata = '0, ctl_data = '0;
  logic [DW-1:0] cpu_rdata, txo_data;
  logic          dma_req, txo_valid, irq;
  int checks = 0, errors = 0;

  txwm_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) i_txwm_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata),
    .txo_valid(txo_valid), .txo_ready(txo_ready), .txo_data(txo_data),
    .ctl_load(ctl_load), .ctl_data(ctl_data), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = DW'(d);
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    cpu_rd = 1; cpu_addr = a;
    #1 v = int'(cpu_rdata);
    @(negedge clk);
    cpu_rd = 0;
  endtask

  task automatic load_ctl(input int d);
    @(negedge clk);
    ctl_load = 1; ctl_data = DW'(d);
    @(negedge clk);
    ctl_load = 0;
  endtask

  function automatic int thr_of(input int wm);
    case (wm)
      0: return 1;
      1: return DEPTH / 4;
      2: return DEPTH / 2;
      default: return (3 * DEPTH) / 4;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    rd(3'd1, v); chk("R10 status", v, 0);
    rd(3'd2, v); chk("R10 ctrl", v, 0);
    #1 chk("R10 dma_req", dma_req, 0);
    chk("R10 irq", irq, 0);
    chk("R10 txo_valid", txo_valid, 0);

    // R1 sweep: every watermark, every fill level
    for (int wm = 0; wm < 4; wm++) begin
      wr(3'd2, 32'h5 | (wm << 4));
      for (int fill = 0; fill <= DEPTH; fill++) begin
        if (fill > 0) wr(3'd0, (wm << 8) | fill);
        rd(3'd1, v);
        chk("R1 txreq", (v >> 2) & 1, (DEPTH - fill) > thr_of(wm));
        chk("R8 reserved", (v >> 1) & 1, 0);
        #1 chk("R3 dma_req", dma_req, (DEPTH - fill) > thr_of(wm));
      end
      // R4 overflow on full write
      wr(3'd0, 16'hdead);
      rd(3'd1, v); chk("R4 ovf set", (v >> 3) & 1, 1);
      wr(3'd1, 32'h8);
      rd(3'd1, v); chk("R4 ovf clear", (v >> 3) & 1, 0);
      // R5 drain in order
      @(negedge clk); txo_ready = 1;
      for (int i = 1; i <= DEPTH; i++) begin
        #1 chk("R5 valid", txo_valid, 1);
        chk("R5 order", txo_data, (wm << 8) | i);
        @(negedge clk);
      end
      txo_ready = 0;
      #1 chk("R5 empty", txo_valid, 0);
    end

    // R3 DMA mode disabled gates dma_req
    wr(3'd2, 32'h1);
    rd(3'd1, v); chk("R1 txreq no dma", (v >> 2) & 1, 1);
    #1 chk("R3 dma gated", dma_req, 0);

    // R2 transmit disabled
    wr(3'd2, 32'h4);
    rd(3'd1, v); chk("R2 txreq off", (v >> 2) & 1, 0);
    #1 chk("R2 dma_req off", dma_req, 0);
    wr(3'd0, 16'h0123);
    #1 chk("R5 valid needs tx_en", txo_valid, 0);
    wr(3'd2, 32'h5);
    #1 chk("R5 valid enabled", txo_valid, 1);
    @(negedge clk); txo_ready = 1;
    #1 chk("R5 data", txo_data, 16'h0123);
    @(negedge clk); txo_ready = 0;
    #1 chk("R5 drained", txo_valid, 0);

    // R3 one-cycle gap after DMA ack
    chk("R3 req before", dma_req, 1);
    @(negedge clk); dma_ack = 1; dma_wdata = 16'hbeef;
    @(negedge clk); dma_ack = 0;
    #1 chk("R3 gap", dma_req, 0);
    @(negedge clk);
    #1 chk("R3 reassert", dma_req, 1);
    // R4 simultaneous DMA and CPU write: CPU dropped
    @(negedge clk); dma_ack = 1; dma_wdata = 16'hcafe;
    cpu_wr = 1; cpu_addr = 3'd0; cpu_wdata = 16'h1111;
    @(negedge clk); dma_ack = 0; cpu_wr = 0;
    rd(3'd1, v); chk("R4 clash ovf", (v >> 3) & 1, 1);
    @(negedge clk); txo_ready = 1;
    #1 chk("R3 dma data", txo_data, 16'hbeef);
    @(negedge clk);
    #1 chk("R4 dma wins", txo_data, 16'hcafe);
    @(negedge clk); txo_ready = 0;
    #1 chk("R4 cpu dropped", txo_valid, 0);

    // R9 overflow interrupt
    wr(3'd3, 32'h8);
    #1 chk("R9 ovf irq", irq, 1);
    wr(3'd1, 32'h8);
    #1 chk("R9 ovf irq clear", irq, 0);
    wr(3'd3, 32'h4);
    #1 chk("R9 txreq irq", irq, 1);
    wr(3'd3, 32'h2);
    rd(3'd3, v); chk("R8 ie reserved", v, 0);
    #1 chk("R9 masked", irq, 0);

    // R6 / R7 control data
    wr(3'd2, 32'h2);
    load_ctl(16'h00aa);
    rd(3'd1, v); chk("R6 ready", v & 1, 1);
    load_ctl(16'h00bb);
    rd(3'd1, v); chk("R6 still ready", v & 1, 1);
    rd(3'd4, v); chk("R6 newest", v, 16'h00bb);
    rd(3'd1, v); chk("R7 cleared", v & 1, 0);
    wr(3'd2, 32'h0);
    load_ctl(16'h00cc);
    wr(3'd2, 32'h2);
    rd(3'd1, v); chk("R7 ignored flag", v & 1, 0);
    rd(3'd4, v); chk("R7 ignored data", v, 16'h00bb);
    load_ctl(16'h00dd);
    wr(3'd2, 32'h0);
    rd(3'd1, v); chk("R7 masked off", v & 1, 0);
    wr(3'd2, 32'h2);
    rd(3'd1, v); chk("R7 unmasked", v & 1, 1);
    wr(3'd3, 32'h1);
    #1 chk("R9 ctl irq", irq, 1);
    wr(3'd3, 32'h0);
    #1 chk("R9 ctl irq off", irq, 0);
    wr(3'd1, 32'h2);
    rd(3'd1, v); chk("R8 status bit1", (v >> 1) & 1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule